// File: doc/BRIEF.md
# Partial-Address Byte-Map Clash Detector

This block keeps a small table of pending memory accesses and reports, without any clock of delay, which of them overlap. Every table entry describes one access as two slots. The first slot is the line the access starts in. The second slot is the following line, and it is used only when the access spills past the line end. Each slot stores a line address and a byte map. The byte map has one bit per byte of the line. It already marks the bytes the access touches, so two maps are ANDed bit for bit and never shifted.

To save comparator width and storage, each slot keeps only the low `CMP_W` bits of its line address. Two accesses to different lines whose low bits agree are therefore reported as clashing. This false positive is deliberate: ordering logic that reads the result can only become more conservative, never less. The result is an N-by-N clash matrix plus a per-entry summary bit. The caller uses them to hold back a load or store until the accesses it conflicts with have left the table.

Entries are loaded through a valid/ready write port. `wr_ready` is always high, so the port never applies back-pressure, and a write is taken on every clock edge where `wr_valid` is high. Entries are released through a plain clear strobe. Both take effect at the clock edge, and the matrix reflects the new table state directly after that edge.

Top module: `lsq_clash_detect`

## Requirements
- R1: While `rst` is high and directly after it falls, `entry_valid`, `clash_mat` and `clash_any` are all zero.
- R2: `wr_ready` is always 1. A rising clock edge with `wr_valid` high loads entry `wr_idx` and marks it valid. The clash outputs reflect the new entry directly after that edge. With `wr_valid` low, the write inputs have no effect.
- R3: Two slots clash when both are active, bits `[CMP_W-1:0]` of their line addresses are equal, and the AND of their byte maps is nonzero. The first slot of an entry is active whenever the entry is valid.
- R4: Line-address bits at `CMP_W` and above are ignored. Two accesses whose addresses differ only there, and whose byte maps overlap, are reported as clashing.
- R5: The overflow slot of an entry is active only when `wr_ovf_act` was 1 at the write. When it is inactive, its address and map never cause a clash.
- R6: Entry i clashes with entry j when any slot of i clashes with any slot of j: first with first, first with overflow, overflow with first, or overflow with overflow.
- R7: `clash_mat[i*N+j]` is 1 when entry i clashes with entry j. The bit for i equal to j is always 0, and the matrix is symmetric.
- R8: A rising edge with `clr_valid` high makes entry `clr_idx` invalid. Every clash involving that entry is gone directly after that edge. Clearing an entry that is already invalid changes nothing.
- R9: If a write and a clear address the same entry at the same edge, the write wins and the entry holds the new access. A clear of a different entry at the same edge still takes effect.
- R10: `clash_any[i]` is the OR of row i of `clash_mat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accept, always 1 |
| wr_idx | input | IDX_W | Entry to load |
| wr_pri_addr | input | ADDR_W | Line address of the first slot |
| wr_pri_map | input | MAP_W | Byte map of the first slot |
| wr_ovf_act | input | 1 | Overflow slot takes part |
| wr_ovf_addr | input | ADDR_W | Line address of the overflow slot |
| wr_ovf_map | input | MAP_W | Byte map of the overflow slot |
| clr_valid | input | 1 | Clear request |
| clr_idx | input | IDX_W | Entry to clear |
| entry_valid | output | N | Per-entry valid flags |
| clash_mat | output | N*N | Clash matrix; bit i*N+j is entry i against entry j |
| clash_any | output | N | Entry i clashes with some other entry |

## Verification
Writes and clears are registered once. The clash logic after those registers is purely combinational, so each result is due one clock edge after the stimulus that causes it and never later. The bench applies stimulus at the falling edge. Its behavioural model updates on the rising edge that the design samples. At the next falling edge, it compares `entry_valid`, the whole matrix and the summary bits with the model. No result is ever sampled while it is still settling on the edge it depends on.

// File: rtl/lsq_clash_pkg.sv
package lsq_clash_pkg;
  // Number of address slots held by one entry: first line and overflow line.
  localparam int SLOTS = 2;

  typedef enum logic [0:0] {
    SLOT_FIRST = 1'b0,
    SLOT_OVF   = 1'b1
  } slot_e;
endpackage

// File: rtl/lsq_slot_cmp.sv
// Compares one slot against another: active, equal partial tag, overlapping bytes.
module lsq_slot_cmp #(
  parameter int CMP_W = 4,
  parameter int MAP_W = 16
) (
  input  logic             a_act,
  input  logic [CMP_W-1:0] a_tag,
  input  logic [MAP_W-1:0] a_map,
  input  logic             b_act,
  input  logic [CMP_W-1:0] b_tag,
  input  logic [MAP_W-1:0] b_map,
  output logic             hit
);
  logic tag_eq;
  logic bytes_meet;

  assign tag_eq     = (a_tag == b_tag);
  assign bytes_meet = |(a_map & b_map);
  assign hit        = a_act & b_act & tag_eq & bytes_meet;
endmodule

// File: rtl/lsq_pair_cmp.sv
// Cross-compares every slot of entry A with every slot of entry B.
module lsq_pair_cmp
  import lsq_clash_pkg::*;
#(
  parameter int CMP_W = 4,
  parameter int MAP_W = 16
) (
  input  logic             a_valid,
  input  logic [CMP_W-1:0] a_pri_tag,
  input  logic [MAP_W-1:0] a_pri_map,
  input  logic             a_ovf_act,
  input  logic [CMP_W-1:0] a_ovf_tag,
  input  logic [MAP_W-1:0] a_ovf_map,
  input  logic             b_valid,
  input  logic [CMP_W-1:0] b_pri_tag,
  input  logic [MAP_W-1:0] b_pri_map,
  input  logic             b_ovf_act,
  input  logic [CMP_W-1:0] b_ovf_tag,
  input  logic [MAP_W-1:0] b_ovf_map,
  output logic             hit
);
  logic [SLOTS-1:0]            a_act, b_act;
  logic [SLOTS-1:0][CMP_W-1:0] a_tag, b_tag;
  logic [SLOTS-1:0][MAP_W-1:0] a_map, b_map;
  logic [SLOTS*SLOTS-1:0]      slot_hit;

  assign a_act[SLOT_FIRST] = a_valid;
  assign a_act[SLOT_OVF]   = a_valid & a_ovf_act;
  assign a_tag[SLOT_FIRST] = a_pri_tag;
  assign a_tag[SLOT_OVF]   = a_ovf_tag;
  assign a_map[SLOT_FIRST] = a_pri_map;
  assign a_map[SLOT_OVF]   = a_ovf_map;

  assign b_act[SLOT_FIRST] = b_valid;
  assign b_act[SLOT_OVF]   = b_valid & b_ovf_act;
  assign b_tag[SLOT_FIRST] = b_pri_tag;
  assign b_tag[SLOT_OVF]   = b_ovf_tag;
  assign b_map[SLOT_FIRST] = b_pri_map;
  assign b_map[SLOT_OVF]   = b_ovf_map;

  for (genvar sa = 0; sa < SLOTS; sa++) begin : g_sa
    for (genvar sb = 0; sb < SLOTS; sb++) begin : g_sb
      lsq_slot_cmp #(.CMP_W(CMP_W), .MAP_W(MAP_W)) u_slot (
        .a_act (a_act[sa]),
        .a_tag (a_tag[sa]),
        .a_map (a_map[sa]),
        .b_act (b_act[sb]),
        .b_tag (b_tag[sb]),
        .b_map (b_map[sb]),
        .hit   (slot_hit[sa*SLOTS+sb])
      );
    end
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/lsq_entry_store.sv
// Entry table: valid flags plus truncated tags and byte maps per slot.
module lsq_entry_store #(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 4,
  parameter int MAP_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [ADDR_W-1:0]         wr_pri_addr,
  input  logic [MAP_W-1:0]          wr_pri_map,
  input  logic                      wr_ovf_act,
  input  logic [ADDR_W-1:0]         wr_ovf_addr,
  input  logic [MAP_W-1:0]          wr_ovf_map,
  input  logic                      clr_en,
  input  logic [IDX_W-1:0]          clr_idx,
  output logic [N-1:0]              ent_valid,
  output logic [N-1:0][CMP_W-1:0]   pri_tag,
  output logic [N-1:0][MAP_W-1:0]   pri_map,
  output logic [N-1:0]              ovf_act,
  output logic [N-1:0][CMP_W-1:0]   ovf_tag,
  output logic [N-1:0][MAP_W-1:0]   ovf_map
);
  // Only the low CMP_W address bits are kept; the rest never reach a flop.
  logic [CMP_W-1:0] pri_low, ovf_low;
  logic             unused_hi_bits;

  assign pri_low = wr_pri_addr[CMP_W-1:0];
  assign ovf_low = wr_ovf_addr[CMP_W-1:0];
  assign unused_hi_bits = ^{wr_pri_addr[ADDR_W-1:CMP_W], wr_ovf_addr[ADDR_W-1:CMP_W]};

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic wr_hit, clr_hit;
    assign wr_hit  = wr_en  && (wr_idx  == IDX_W'(i));
    assign clr_hit = clr_en && (clr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[i] <= 1'b0;
        ovf_act[i]   <= 1'b0;
      end else if (wr_hit) begin
        ent_valid[i] <= 1'b1;
        ovf_act[i]   <= wr_ovf_act;
      end else if (clr_hit) begin
        ent_valid[i] <= 1'b0;
        ovf_act[i]   <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_hit) begin
        pri_tag[i] <= pri_low;
        pri_map[i] <= wr_pri_map;
        ovf_tag[i] <= ovf_low;
        ovf_map[i] <= wr_ovf_map;
      end
    end
  end
endmodule

// File: rtl/lsq_clash_detect.sv
// Top: entry table plus one pair comparator per unordered entry pair.
module lsq_clash_detect
  import lsq_clash_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 4,
  parameter int MAP_W  = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [ADDR_W-1:0]   wr_pri_addr,
  input  logic [MAP_W-1:0]    wr_pri_map,
  input  logic                wr_ovf_act,
  input  logic [ADDR_W-1:0]   wr_ovf_addr,
  input  logic [MAP_W-1:0]    wr_ovf_map,
  input  logic                clr_valid,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [N-1:0]        entry_valid,
  output logic [N*N-1:0]      clash_mat,
  output logic [N-1:0]        clash_any
);
  logic [N-1:0][CMP_W-1:0] pri_tag, ovf_tag;
  logic [N-1:0][MAP_W-1:0] pri_map, ovf_map;
  logic [N-1:0]            ovf_act;
  logic [N-1:0][N-1:0]     pair_hit;

  // R2: the write port never back-pressures.
  assign wr_ready = 1'b1;

  lsq_entry_store #(
    .N(N), .ADDR_W(ADDR_W), .CMP_W(CMP_W), .MAP_W(MAP_W), .IDX_W(IDX_W)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_valid & wr_ready),
    .wr_idx      (wr_idx),
    .wr_pri_addr (wr_pri_addr),
    .wr_pri_map  (wr_pri_map),
    .wr_ovf_act  (wr_ovf_act),
    .wr_ovf_addr (wr_ovf_addr),
    .wr_ovf_map  (wr_ovf_map),
    .clr_en      (clr_valid),
    .clr_idx     (clr_idx),
    .ent_valid   (entry_valid),
    .pri_tag     (pri_tag),
    .pri_map     (pri_map),
    .ovf_act     (ovf_act),
    .ovf_tag     (ovf_tag),
    .ovf_map     (ovf_map)
  );

  // One comparator per unordered pair, mirrored across the diagonal (R6, R7).
  for (genvar i = 0; i < N; i++) begin : g_row
    assign pair_hit[i][i] = 1'b0;
    for (genvar j = i + 1; j < N; j++) begin : g_col
      logic hit;
      lsq_pair_cmp #(.CMP_W(CMP_W), .MAP_W(MAP_W)) u_pair (
        .a_valid   (entry_valid[i]),
        .a_pri_tag (pri_tag[i]),
        .a_pri_map (pri_map[i]),
        .a_ovf_act (ovf_act[i]),
        .a_ovf_tag (ovf_tag[i]),
        .a_ovf_map (ovf_map[i]),
        .b_valid   (entry_valid[j]),
        .b_pri_tag (pri_tag[j]),
        .b_pri_map (pri_map[j]),
        .b_ovf_act (ovf_act[j]),
        .b_ovf_tag (ovf_tag[j]),
        .b_ovf_map (ovf_map[j]),
        .hit       (hit)
      );
      assign pair_hit[i][j] = hit;
      assign pair_hit[j][i] = hit;
    end
  end

  // Bit i*N+j of the flat port is row i, column j.
  assign clash_mat = pair_hit;

  // R10: per-entry summary.
  always_comb begin
    for (int i = 0; i < N; i++) clash_any[i] = |pair_hit[i];
  end
endmodule

// File: rtl/lsq_clash_detect_chk.sv
module lsq_clash_detect_chk #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic [IDX_W-1:0] wr_idx,
  input logic             clr_valid,
  input logic [IDX_W-1:0] clr_idx,
  input logic [N-1:0]     entry_valid,
  input logic [N*N-1:0]   clash_mat,
  input logic [N-1:0]     clash_any
);
  function automatic logic [N*N-1:0] flip(input logic [N*N-1:0] m);
    logic [N*N-1:0] t;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) t[j*N+i] = m[i*N+j];
    return t;
  endfunction

  function automatic logic [N*N-1:0] diag_bits(input logic [N*N-1:0] m);
    logic [N*N-1:0] d;
    d = '0;
    for (int i = 0; i < N; i++) d[i*N+i] = m[i*N+i];
    return d;
  endfunction

  function automatic logic row_or(input logic [N*N-1:0] m, input logic [IDX_W-1:0] r);
    logic o;
    o = 1'b0;
    for (int j = 0; j < N; j++) o |= m[int'(r)*N+j];
    return o;
  endfunction

  function automatic logic [N-1:0] all_rows(input logic [N*N-1:0] m);
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) o[i] = row_or(m, IDX_W'(i));
    return o;
  endfunction

  // R7: no self clash
  a_r7_no_self: assert property (@(posedge clk) disable iff (rst)
    diag_bits(clash_mat) == '0);

  // R7: symmetric
  a_r7_symmetric: assert property (@(posedge clk) disable iff (rst)
    clash_mat == flip(clash_mat));

  // R2: an accepted write leaves the entry valid
  a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> entry_valid[$past(wr_idx)]);

  // R8: a clear not overridden by a write drops the entry and its row
  a_r8_clear_drops_row: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && !(wr_valid && wr_idx == clr_idx))
      |=> (!entry_valid[$past(clr_idx)] && !row_or(clash_mat, $past(clr_idx))));

  // R10: summary matches the matrix rows
  a_r10_any_matches_rows: assert property (@(posedge clk) disable iff (rst)
    clash_any == all_rows(clash_mat));
endmodule

bind lsq_clash_detect lsq_clash_detect_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_valid    (wr_valid),
  .wr_idx      (wr_idx),
  .clr_valid   (clr_valid),
  .clr_idx     (clr_idx),
  .entry_valid (entry_valid),
  .clash_mat   (clash_mat),
  .clash_any   (clash_any)
);

// File: tb/lsq_clash_detect_bench.sv
`timescale 1ns/1ps
module lsq_clash_detect_bench;
  localparam int N      = 4;
  localparam int ADDR_W = 32;
  localparam int CMP_W  = 4;
  localparam int MAP_W  = 16;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [ADDR_W-1:0] wr_pri_addr = '0;
  logic [MAP_W-1:0]  wr_pri_map = '0;
  logic              wr_ovf_act = 1'b0;
  logic [ADDR_W-1:0] wr_ovf_addr = '0;
  logic [MAP_W-1:0]  wr_ovf_map = '0;
  logic              clr_valid = 1'b0;
  logic [IDX_W-1:0]  clr_idx = '0;
  logic [N-1:0]      entry_valid;
  logic [N*N-1:0]    clash_mat;
  logic [N-1:0]      clash_any;

  always #10 clk = ~clk;

  lsq_clash_detect #(.N(N), .ADDR_W(ADDR_W), .CMP_W(CMP_W), .MAP_W(MAP_W)) u_lsq_clash_detect (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .wr_pri_addr(wr_pri_addr), .wr_pri_map(wr_pri_map), .wr_ovf_act(wr_ovf_act),
    .wr_ovf_addr(wr_ovf_addr), .wr_ovf_map(wr_ovf_map), .clr_valid(clr_valid),
    .clr_idx(clr_idx), .entry_valid(entry_valid), .clash_mat(clash_mat), .clash_any(clash_any)
  );

  // Behavioural reference: one record per entry, full addresses kept.
  bit                m_val [N];
  logic [ADDR_W-1:0] m_pa [N];
  logic [MAP_W-1:0]  m_pm [N];
  bit                m_oact [N];
  logic [ADDR_W-1:0] m_oa [N];
  logic [MAP_W-1:0]  m_om [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_oact[i] = 0; end
    end else begin
      if (clr_valid && !(wr_valid && wr_idx == clr_idx)) begin
        m_val[clr_idx] = 0; m_oact[clr_idx] = 0;
      end
      if (wr_valid) begin
        m_val[wr_idx] = 1; m_pa[wr_idx] = wr_pri_addr; m_pm[wr_idx] = wr_pri_map;
        m_oact[wr_idx] = wr_ovf_act; m_oa[wr_idx] = wr_ovf_addr; m_om[wr_idx] = wr_ovf_map;
      end
    end
  end

  function automatic bit slot_meet(bit aa, logic [ADDR_W-1:0] ad, logic [MAP_W-1:0] am,
                                   bit ba, logic [ADDR_W-1:0] bd, logic [MAP_W-1:0] bm);
    return aa && ba && ((ad % (1 << CMP_W)) == (bd % (1 << CMP_W))) && ((am & bm) != 0);
  endfunction

  function automatic bit model_clash(int i, int j);
    bit r;
    if (i == j || !m_val[i] || !m_val[j]) return 0;
    r = slot_meet(1, m_pa[i], m_pm[i], 1, m_pa[j], m_pm[j]);
    r |= slot_meet(1, m_pa[i], m_pm[i], m_oact[j], m_oa[j], m_om[j]);
    r |= slot_meet(m_oact[i], m_oa[i], m_om[i], 1, m_pa[j], m_pm[j]);
    r |= slot_meet(m_oact[i], m_oa[i], m_om[i], m_oact[j], m_oa[j], m_om[j]);
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    logic [N*N-1:0] em;
    logic [N-1:0]   ea, ev;
    em = '0; ea = '0; ev = '0;
    for (int i = 0; i < N; i++) begin
      ev[i] = m_val[i];
      for (int j = 0; j < N; j++) begin
        em[i*N+j] = model_clash(i, j);
        if (em[i*N+j]) ea[i] = 1'b1;
      end
    end
    check(entry_valid == ev, req, "entry_valid", entry_valid, ev);
    check(clash_mat == em, req, "clash_mat", clash_mat, em);
    check(clash_any == ea, req, "clash_any", clash_any, ea);
    check(wr_ready == 1'b1, "R2", "wr_ready", wr_ready, 1);
  endtask

  // One edge; inputs return to idle at the next falling edge, then compare.
  task automatic step(string req);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 0; clr_valid = 0;
    compare(req);
  endtask

  task automatic put(int idx, logic [ADDR_W-1:0] pa, logic [MAP_W-1:0] pm,
                     bit oact, logic [ADDR_W-1:0] oa, logic [MAP_W-1:0] om);
    wr_valid = 1; wr_idx = IDX_W'(idx); wr_pri_addr = pa; wr_pri_map = pm;
    wr_ovf_act = oact; wr_ovf_addr = oa; wr_ovf_map = om;
  endtask

  task automatic drop(int idx);
    clr_valid = 1; clr_idx = IDX_W'(idx);
  endtask

  task automatic drop_all(string req);
    for (int i = 0; i < N; i++) begin drop(i); step(req); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst = 0;
    @(negedge clk);
    compare("R1");
    check(clash_mat == '0, "R1", "matrix after reset", clash_mat, 0);

    // R3: same partial tag, disjoint maps, then overlapping maps, then other tag
    put(0, 32'h5, 16'h00F0, 0, 32'h0, 16'h0); step("R2");
    put(1, 32'h5, 16'h0100, 0, 32'h0, 16'h0); step("R3");
    check(clash_mat[0*N+1] == 1'b0, "R3", "disjoint maps", clash_mat[0*N+1], 0);
    put(1, 32'h5, 16'h0010, 0, 32'h0, 16'h0); step("R3");
    check(clash_mat[0*N+1] == 1'b1, "R3", "overlapping maps", clash_mat[0*N+1], 1);
    check(clash_mat[1*N+0] == 1'b1, "R7", "mirror bit", clash_mat[1*N+0], 1);
    put(2, 32'h6, 16'h00F0, 0, 32'h0, 16'h0); step("R3");
    check(clash_any[2] == 1'b0, "R3", "different tag", clash_any[2], 0);

    // R4: upper address bits differ only: false positive expected
    put(3, 32'hABC0_0105, 16'h0080, 0, 32'h0, 16'h0); step("R4");
    check(clash_mat[0*N+3] == 1'b1, "R4", "upper bits ignored", clash_mat[0*N+3], 1);

    // R2: write inputs moving without wr_valid change nothing
    wr_idx = 2'd3; wr_pri_addr = 32'h7; wr_pri_map = 16'hFFFF; step("R2");
    check(clash_mat[0*N+3] == 1'b1, "R2", "idle write ignored", clash_mat[0*N+3], 1);

    // R8: clear entry 1 then clear it again while already invalid
    drop(1); step("R8");
    check(clash_mat[1*N+0] == 1'b0, "R8", "cleared row", clash_mat[1*N+0], 0);
    drop(1); step("R8");
    check(clash_mat[0*N+3] == 1'b1, "R8", "others untouched", clash_mat[0*N+3], 1);

    // R9: write and clear on same entry at once; write wins
    put(1, 32'h5, 16'h0020, 0, 32'h0, 16'h0); drop(1); step("R9");
    check(entry_valid[1] == 1'b1, "R9", "write wins", entry_valid[1], 1);
    check(clash_mat[0*N+1] == 1'b1, "R9", "new data live", clash_mat[0*N+1], 1);
    // write entry 2 and clear entry 3 together
    put(2, 32'h9, 16'h0001, 0, 32'h0, 16'h0); drop(3); step("R9");
    check(entry_valid[3] == 1'b0, "R9", "other clear applied", entry_valid[3], 0);

    // R5 / R6: overflow slots
    drop_all("R8");
    put(0, 32'h1, 16'hC000, 1, 32'h2, 16'h0001); step("R5");
    put(1, 32'h2, 16'h0003, 0, 32'h0, 16'h0); step("R6");
    check(clash_mat[0*N+1] == 1'b1, "R6", "overflow vs first", clash_mat[0*N+1], 1);
    put(2, 32'h3, 16'h0001, 0, 32'h2, 16'h0001); step("R5");
    check(clash_any[2] == 1'b0, "R5", "inactive overflow", clash_any[2], 0);
    put(3, 32'h9, 16'h0001, 1, 32'h2, 16'h0001); step("R6");
    check(clash_mat[3*N+0] == 1'b1, "R6", "overflow vs overflow", clash_mat[3*N+0], 1);
    check(clash_mat[3*N+1] == 1'b1, "R6", "overflow vs first b", clash_mat[3*N+1], 1);
    check(clash_mat[3*N+3] == 1'b0, "R7", "diagonal", clash_mat[3*N+3], 0);

    // Mixed traffic on a narrow address range so clashes are frequent
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 2) != 0)
        put(int'($urandom_range(0, N-1)), 32'($urandom_range(0, 40)), 16'($urandom),
            bit'($urandom_range(0, 1)), 32'($urandom_range(0, 40)), 16'($urandom));
      if ($urandom_range(0, 2) == 0) drop(int'($urandom_range(0, N-1)));
      step("R10");
    end

    rst = 1; step("R1");
    rst = 0; @(negedge clk); compare("R1");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule